// File: doc/BRIEF.md
# Watermark Interrupt Status Aggregator

This block gathers the interrupt sources of a message controller into one line. It holds a 15-bit status vector whose flags are sticky, a 15-bit enable vector, a write-one-to-clear strobe register and a 16-bit watermark register. Single-cycle event pulses arrive from the protocol engine. Occupancy counts arrive from the transmit queue, the high-priority transmit slot and the receive queue, each as a count of 32-bit words. The block converts the word counts into whole frames of four words and sets the level-derived flags from these conditions:

- empty and full tests on each queue;
- two programmable frame-count watermark comparisons.

Software reads status, enable and watermark through a small select-based read port. It writes enable, clear and watermark through a matching write port. The interrupt output is a registered level. It is high whenever an enabled status flag is set, so the line stays free of glitches. A flag stays set until software clears it. When a set condition and a clear land in the same cycle, the set is kept.

Top module: `irq_watermark_agg`

## Requirements
- R1: After reset the status vector reads 0x6000, the enable vector reads 0, the watermark register reads 0x3f3f and `irq` is low.
- R2: Event bit i of `evtPulse` sets status bit i on the next clock edge. The status layout is fixed:

  | Bit | Flag |
  |-----|------|
  | 14 | tx-queue-empty |
  | 13 | tx-watermark |
  | 12 | rx-watermark |
  | 11 | wakeup |
  | 10 | sleep |
  | 9 | bus-off |
  | 8 | error |
  | 7 | rx-not-empty |
  | 6 | rx-overflow |
  | 5 | rx-underflow |
  | 4 | rx-ok |
  | 3 | priority-slot-full |
  | 2 | tx-queue-full |
  | 1 | tx-ok |
  | 0 | arbitration-lost |

- R3: Four level conditions set flags on the next edge:
  - bit 14 when `txUsedWords` is 0;
  - bit 2 when `txUsedWords` equals TX_FRAMES*4;
  - bit 3 when `hpbUsedWords` equals HPB_FRAMES*4;
  - bit 7 when `rxUsedWords` is at least 4 (one whole frame).
- R4: Two watermark conditions set flags on the next edge:
  - bit 13 when floor((TX_FRAMES*4 - `txUsedWords`)/4) is greater than watermark bits 15:8;
  - bit 12 when floor(`rxUsedWords`/4) is greater than watermark bits 7:0.
- R5: A set status flag stays set after its cause goes away, until it is cleared.
- R6: A write with `wrSel`=2 clears every status bit whose `wrData` bit is 1 and leaves the others unchanged. Reading with `rdSel`=2 returns 0.
- R7: When a flag's set condition and a clear of that flag occur in the same cycle, the flag ends up set.
- R8: The status vector is read-only. A write with `wrSel`=0 changes nothing. It is read with `rdSel`=0, in `rdData` bits 14:0.
- R9: `irq` equals the OR of (status AND enable) and is updated on the same clock edge as the status and enable registers.
- R10: A write with `wrSel`=1 loads `wrData` bits 14:0 into the enable vector, which reads back with `rdSel`=1. A write with `wrSel`=3 loads all 16 bits into the watermark register, which reads back with `rdSel`=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 15 | One-cycle event pulses, one per status bit position |
| txUsedWords | input | clog2(TX_FRAMES*4+1) | Words stored in the transmit queue |
| hpbUsedWords | input | clog2(HPB_FRAMES*4+1) | Words stored in the high-priority transmit slot |
| rxUsedWords | input | clog2(RX_FRAMES*4+1) | Words stored in the receive queue |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 status (ignored), 1 enable, 2 clear, 3 watermark |
| wrData | input | 16 | Write data |
| rdSel | input | 2 | Read select: 0 status, 1 enable, 2 clear (zero), 3 watermark |
| rdData | output | 16 | Combinational read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The in-line assertions check four behaviours on every cycle:
- `irq` always equals the OR of the enabled status flags;
- a set flag survives any cycle that does not clear it;
- a cleared flag with no set pending goes to zero;
- a pending set is always visible after the edge.

The watermark and frame arithmetic can only be shown by the bench, which sweeps every word count against a range of thresholds on both queues. The bench scenarios also show the bit layout of the event inputs, the read-only status register, the reset values and the per-bit masking of the interrupt.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NFLAGS = 15;
  localparam int WORDS_PER_FRAME = 4;

  localparam int B_TXEMPTY = 14;
  localparam int B_TXWM    = 13;
  localparam int B_RXWM    = 12;
  localparam int B_RXNE    = 7;
  localparam int B_HPBFULL = 3;
  localparam int B_TXFULL  = 2;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_ENABLE = 2'd1;
  localparam logic [1:0] SEL_CLEAR  = 2'd2;
  localparam logic [1:0] SEL_WMARK  = 2'd3;

  localparam logic [NFLAGS-1:0] STATUS_RST = 15'h6000;
  localparam logic [15:0]       WMARK_RST  = 16'h3f3f;

  typedef struct packed {
    logic [NFLAGS-1:0] setVec;
    logic [NFLAGS-1:0] clrVec;
    logic              enWe;
    logic              wmWe;
    logic [15:0]       wrData;
  } strobe_t;
endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int TX_FRAMES  = 64,
  parameter int RX_FRAMES  = 64,
  parameter int HPB_FRAMES = 1,
  localparam int TX_WORDS  = TX_FRAMES * WORDS_PER_FRAME,
  localparam int RX_WORDS  = RX_FRAMES * WORDS_PER_FRAME,
  localparam int HPB_WORDS = HPB_FRAMES * WORDS_PER_FRAME,
  localparam int TXCW = $clog2(TX_WORDS + 1),
  localparam int RXCW = $clog2(RX_WORDS + 1),
  localparam int HPCW = $clog2(HPB_WORDS + 1)
) (
  input  logic [TXCW-1:0]   txUsedWords,
  input  logic [HPCW-1:0]   hpbUsedWords,
  input  logic [RXCW-1:0]   rxUsedWords,
  input  logic [NFLAGS-1:0] evtPulse,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [15:0]       wrData,
  input  logic [15:0]       wmarkQ,
  output strobe_t           strb
);
  int txFreeFrames;
  int rxFrames;
  logic [NFLAGS-1:0] levelSet;

  always_comb begin
    txFreeFrames = (TX_WORDS - int'(txUsedWords)) / WORDS_PER_FRAME;
    rxFrames     = int'(rxUsedWords) / WORDS_PER_FRAME;
    levelSet = '0;
    levelSet[B_TXEMPTY] = (int'(txUsedWords) == 0);
    levelSet[B_TXFULL]  = (int'(txUsedWords) == TX_WORDS);
    levelSet[B_HPBFULL] = (int'(hpbUsedWords) == HPB_WORDS);
    levelSet[B_RXNE]    = (int'(rxUsedWords) >= WORDS_PER_FRAME);
    levelSet[B_TXWM]    = (txFreeFrames > int'(wmarkQ[15:8]));
    levelSet[B_RXWM]    = (rxFrames > int'(wmarkQ[7:0]));
  end

  always_comb begin
    strb.setVec = evtPulse | levelSet;
    strb.clrVec = (wrEn && wrSel == SEL_CLEAR) ? wrData[NFLAGS-1:0] : '0;
    strb.enWe   = wrEn && (wrSel == SEL_ENABLE);
    strb.wmWe   = wrEn && (wrSel == SEL_WMARK);
    strb.wrData = wrData;
  end
endmodule

// File: rtl/irqagg_dp.sv
module irqagg_dp
  import irqagg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  strobe_t     strb,
  input  logic [1:0]  rdSel,
  output logic [15:0] rdData,
  output logic [15:0] wmarkQ,
  output logic        irq
);
  logic [NFLAGS-1:0] statusQ, statusNext;
  logic [NFLAGS-1:0] enableQ, enableNext;
  logic              irqQ;

  always_comb begin
    statusNext = (statusQ & ~strb.clrVec) | strb.setVec;
    enableNext = strb.enWe ? strb.wrData[NFLAGS-1:0] : enableQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= STATUS_RST;
      enableQ <= '0;
      wmarkQ  <= WMARK_RST;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      enableQ <= enableNext;
      if (strb.wmWe) wmarkQ <= strb.wrData;
      irqQ    <= |(statusNext & enableNext);
    end
  end

  always_comb begin
    case (rdSel)
      SEL_STATUS: rdData = {1'b0, statusQ};
      SEL_ENABLE: rdData = {1'b0, enableQ};
      SEL_CLEAR:  rdData = '0;
      default:    rdData = wmarkQ;
    endcase
  end

  assign irq = irqQ;

  // R9: line tracks enabled flags
  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ == |(statusQ & enableQ));

  // R5: flags not cleared survive the edge
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusQ & $past(statusQ & ~strb.clrVec)) == $past(statusQ & ~strb.clrVec)));

  // R7: a set in the clear cycle is kept
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusQ & $past(strb.setVec)) == $past(strb.setVec)));

  // R6: cleared flags without a set drop
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusQ & $past(strb.clrVec & ~strb.setVec)) == '0));
endmodule

// File: rtl/irq_watermark_agg.sv
module irq_watermark_agg
  import irqagg_pkg::*;
#(
  parameter int TX_FRAMES  = 64,
  parameter int RX_FRAMES  = 64,
  parameter int HPB_FRAMES = 1,
  localparam int TXCW = $clog2(TX_FRAMES * WORDS_PER_FRAME + 1),
  localparam int RXCW = $clog2(RX_FRAMES * WORDS_PER_FRAME + 1),
  localparam int HPCW = $clog2(HPB_FRAMES * WORDS_PER_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] evtPulse,
  input  logic [TXCW-1:0]   txUsedWords,
  input  logic [HPCW-1:0]   hpbUsedWords,
  input  logic [RXCW-1:0]   rxUsedWords,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [15:0]       wrData,
  input  logic [1:0]        rdSel,
  output logic [15:0]       rdData,
  output logic              irq
);
  strobe_t     strb;
  logic [15:0] wmarkQ;

  irqagg_ctrl #(
    .TX_FRAMES(TX_FRAMES), .RX_FRAMES(RX_FRAMES), .HPB_FRAMES(HPB_FRAMES)
  ) u_ctrl (
    .txUsedWords(txUsedWords), .hpbUsedWords(hpbUsedWords), .rxUsedWords(rxUsedWords),
    .evtPulse(evtPulse), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wmarkQ(wmarkQ), .strb(strb)
  );

  irqagg_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rdSel(rdSel),
    .rdData(rdData), .wmarkQ(wmarkQ), .irq(irq)
  );
endmodule

// File: tb/tb_irq_watermark_agg.sv
module tb_irq_watermark_agg;
  localparam int TXF = 8, RXF = 8, HPF = 1;
  localparam int TXW = TXF * 4, RXW = RXF * 4, HPW = HPF * 4;
  localparam int TXCW = $clog2(TXW + 1), RXCW = $clog2(RXW + 1), HPCW = $clog2(HPW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] evtPulse = '0;
  logic [TXCW-1:0] txUsedWords = TXCW'(4);
  logic [HPCW-1:0] hpbUsedWords = '0;
  logic [RXCW-1:0] rxUsedWords = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0, rdSel = '0;
  logic [15:0] wrData = '0, rdData;
  logic irq;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_watermark_agg #(.TX_FRAMES(TXF), .RX_FRAMES(RXF), .HPB_FRAMES(HPF)) dut (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .txUsedWords(txUsedWords),
    .hpbUsedWords(hpbUsedWords), .rxUsedWords(rxUsedWords), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irq(irq));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [15:0] rd(logic [1:0] sel);
    rdSel = sel;
    return rdData;
  endfunction

  task automatic readReg(logic [1:0] sel, output logic [15:0] val);
    rdSel = sel; #1; val = rdData;
  endtask

  task automatic regWrite(logic [1:0] sel, logic [15:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic pulse(logic [14:0] v);
    evtPulse = v; tick(); evtPulse = '0;
  endtask

  function automatic logic [15:0] expLevel(int tx, int rx, int hpb, int txT, int rxT);
    logic [15:0] e;
    e = '0;
    if (tx == 0) e[14] = 1'b1;
    if ((TXW - tx) / 4 > txT) e[13] = 1'b1;
    if (rx / 4 > rxT) e[12] = 1'b1;
    if (rx >= 4) e[7] = 1'b1;
    if (hpb == HPW) e[3] = 1'b1;
    if (tx == TXW) e[2] = 1'b1;
    return e;
  endfunction

  task automatic sweepPoint(string tag, int tx, int rx, int hpb, int txT, int rxT);
    logic [15:0] v;
    txUsedWords = TXCW'(tx); rxUsedWords = RXCW'(rx); hpbUsedWords = HPCW'(hpb);
    regWrite(2'd2, 16'h7fff);
    readReg(2'd0, v);
    chk(tag, v, expLevel(tx, rx, hpb, txT, rxT));
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1: reset values
    readReg(2'd0, v); chk("R1 status reset", v, 16'h6000);
    readReg(2'd1, v); chk("R1 enable reset", v, 16'h0000);
    readReg(2'd3, v); chk("R1 watermark reset", v, 16'h3f3f);
    chk("R1 irq reset", {15'b0, irq}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: clear all, idle counts give no level flags
    regWrite(2'd2, 16'h7fff);
    readReg(2'd0, v); chk("R6 clear all", v, 16'h0000);
    readReg(2'd2, v); chk("R6 clear reads zero", v, 16'h0000);

    // R2: each event bit lands in its own position
    for (int i = 0; i < 15; i++) begin
      pulse(15'(1) << i);
      readReg(2'd0, v); chk("R2 event bit position", v, 16'(1) << i);
      regWrite(2'd2, 16'(1) << i);
      readReg(2'd0, v); chk("R2 event bit cleared", v, 16'h0000);
    end

    // R6: partial clear
    pulse(15'h0042);
    regWrite(2'd2, 16'h0002);
    readReg(2'd0, v); chk("R6 partial clear", v, 16'h0040);
    regWrite(2'd2, 16'h7fff);

    // R7: set and clear in the same cycle
    evtPulse = 15'h0010; wrEn = 1'b1; wrSel = 2'd2; wrData = 16'h7fff;
    tick();
    evtPulse = '0; wrEn = 1'b0;
    readReg(2'd0, v); chk("R7 set wins over clear", v, 16'h0010);
    regWrite(2'd2, 16'h7fff);

    // R5: sticky after cause goes away
    rxUsedWords = RXCW'(8); tick();
    rxUsedWords = '0; tick(); tick(); tick();
    readReg(2'd0, v); chk("R5 rx-not-empty sticky", v, 16'h0080);

    // R8: writes to status are ignored
    regWrite(2'd0, 16'h0000);
    readReg(2'd0, v); chk("R8 status write ignored (zero)", v, 16'h0080);
    regWrite(2'd2, 16'h7fff);
    regWrite(2'd0, 16'h7fff);
    readReg(2'd0, v); chk("R8 status write ignored (ones)", v, 16'h0000);

    // R10: register readback
    regWrite(2'd1, 16'hdaa5);
    readReg(2'd1, v); chk("R10 enable readback", v, 16'h5aa5);
    regWrite(2'd3, 16'hc381);
    readReg(2'd3, v); chk("R10 watermark readback", v, 16'hc381);
    regWrite(2'd1, 16'h0000);

    // R3/R4: sweeps of counts against thresholds
    for (int t = 0; t < 10; t++) begin
      regWrite(2'd3, {8'(t), 8'(t)});
      for (int rx = 0; rx <= RXW; rx++) sweepPoint("R3/R4 rx sweep", 4, rx, 0, t, t);
      for (int tx = 0; tx <= TXW; tx++) sweepPoint("R3/R4 tx sweep", tx, 0, 0, t, t);
    end
    regWrite(2'd3, 16'h3f3f);
    for (int h = 0; h <= HPW; h++) sweepPoint("R3 priority slot sweep", 4, 0, h, 63, 63);
    txUsedWords = TXCW'(4); rxUsedWords = '0; hpbUsedWords = '0;
    regWrite(2'd2, 16'h7fff);

    // R9: interrupt masking per bit
    for (int i = 0; i < 15; i++) begin
      regWrite(2'd1, 16'(1) << i);
      chk("R9 irq low before event", {15'b0, irq}, 16'h0000);
      pulse(15'(1) << i);
      chk("R9 irq on enabled flag", {15'b0, irq}, 16'h0001);
      regWrite(2'd1, 16'h7fff & ~(16'(1) << i));
      chk("R9 irq masked", {15'b0, irq}, 16'h0000);
      regWrite(2'd1, 16'h7fff);
      chk("R9 irq re-enabled", {15'b0, irq}, 16'h0001);
      regWrite(2'd2, 16'h7fff);
      chk("R9 irq drops on clear", {15'b0, irq}, 16'h0000);
      regWrite(2'd1, 16'h0000);
    end

    done = 1;
    finishRun();
  end
endmodule